// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block generates data-memory addresses for a DSP datapath. It holds a small set of index pointers. Each pointer has its own base, length and modify register. Every memory access uses the current value of a pointer as its address and then post-updates that pointer. The update can be a plain linear step, a circular step that stays inside the window given by base and length, or a bit-reversed step that reorders data for radix-2 FFT passes.

A register-write port loads any index, base, length or modify register. Two independent update ports serve the two data moves of a datapath cycle. Each update port names a pointer, picks an addressing mode and a direction, and takes its step from the pointer's own modify register or from an immediate value. Both ports can update pointers in the same cycle. The block outputs the current address seen by each port and the values of all index pointers. Memory and instruction decoding are outside the block.

Top module: `circ_agu`

## Requirements
- R1: Reset (active-low, asynchronous) clears every index, base, length and modify register to zero, so every slice of `idx_flat` reads zero.
- R2: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_kind` (0 index, 1 base, 2 length, 3 modify) of pointer `wr_sel`. A written index appears on `idx_flat[wr_sel*AW +: AW]` after the next clock edge. A written base, length or modify register takes effect for updates in later cycles.
- R3: An update in mode 0 (linear) sets the pointer to its current value plus the step, or minus the step when the direction bit is 1, modulo 2^AW. Mode 3 behaves exactly like mode 0. The new value is visible one clock edge after the update is issued.
- R4: In mode 1 (circular) with a nonzero length, an increment whose sum reaches or passes base+length has the length subtracted once.
- R5: In mode 1 with a nonzero length, a decrement whose difference falls below base has the length added once. A result exactly equal to base is kept as it is.
- R6: In mode 1, a length of zero gives the same result as mode 0.
- R7: The step is the port's immediate when its use-immediate bit is 1. Otherwise it is the modify register of the selected pointer.
- R8: In mode 2 (bit-reversed), the step is added to, or subtracted from, the pointer with the carry or borrow moving from bit AW-1 toward bit 0. For AW=16 with step 0x8000, increments from 0 give 0x8000, 0x4000, 0xC000, 0x2000.
- R9: The two update ports can update two different pointers in the same cycle, and both results take effect.
- R10: When both update ports select the same pointer in one cycle, only port 0's result is stored.
- R11: An index write through the register-write port overrides any update aimed at the same pointer in that cycle. Updates to other pointers in that cycle still take effect.
- R12: `p0_addr` and `p1_addr` show, combinationally, the current (pre-update) value of the pointer each port selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 index, 1 base, 2 length, 3 modify |
| wr_sel | input | SELW | Pointer number for the write |
| wr_data | input | AW | Write data |
| p0_en | input | 1 | Port 0 update strobe |
| p0_sel | input | SELW | Port 0 pointer select |
| p0_mode | input | 2 | Port 0 mode: 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| p0_dec | input | 1 | Port 0 direction, 1 = subtract step |
| p0_use_imm | input | 1 | Port 0 takes its step from p0_imm |
| p0_imm | input | AW | Port 0 immediate step magnitude |
| p1_en | input | 1 | Port 1 update strobe |
| p1_sel | input | SELW | Port 1 pointer select |
| p1_mode | input | 2 | Port 1 mode, same encoding as port 0 |
| p1_dec | input | 1 | Port 1 direction, 1 = subtract step |
| p1_use_imm | input | 1 | Port 1 takes its step from p1_imm |
| p1_imm | input | AW | Port 1 immediate step magnitude |
| p0_addr | output | AW | Current address of the pointer port 0 selects |
| p1_addr | output | AW | Current address of the pointer port 1 selects |
| idx_flat | output | NIDX*AW | All index pointers, pointer i at bits i*AW +: AW |

## Verification
Three actions can land in the same cycle: an update on each port and an index write. The bench drives them together in three combinations. In the first, the two ports target different pointers and step in opposite directions, and both new values are checked. In the second, both ports target one pointer; the stored value must be port 0's result, and port 1's result must not appear. In the third, an index write and a port 0 update hit the same pointer while port 1 updates another pointer; the written value must win and port 1's result must still be stored. The checker compares the stored result in these collisions with the step logic's output from the cycle before.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;

   typedef enum logic [1:0] {
      AM_LINEAR = 2'd0,
      AM_CIRC   = 2'd1,
      AM_BREV   = 2'd2,
      AM_ALT    = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      RK_INDEX  = 2'd0,
      RK_BASE   = 2'd1,
      RK_LENGTH = 2'd2,
      RK_MODIFY = 2'd3
   } rkind_e;

   localparam int NPORT = 2;

endpackage

// File: rtl/circ_agu_step.sv
module circ_agu_step
   import circ_agu_pkg::*;
#(
   parameter int AW      = 16,
   parameter bit BREV_EN = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   input  logic [AW-1:0] mag,
   input  logic [1:0]    mode,
   input  logic          dec,
   output logic [AW-1:0] nxt
);

   localparam int WW = AW + 1;

   logic [AW-1:0] lin_v, circ_v, brev_v;
   logic [WW-1:0] cur_w, mag_w, base_w, len_w;
   logic [WW-1:0] lim_w, up_w, dn_w, up_wrap, dn_wrap;
   logic          over_hi, under_lo;

   assign cur_w  = {1'b0, cur};
   assign mag_w  = {1'b0, mag};
   assign base_w = {1'b0, base};
   assign len_w  = {1'b0, len};

   // linear step, modulo 2^AW
   assign lin_v = dec ? (cur - mag) : (cur + mag);

   // circular step: one add or subtract of the length is enough
   assign lim_w    = base_w + len_w;
   assign up_w     = cur_w + mag_w;
   assign dn_w     = cur_w - mag_w;
   assign up_wrap  = up_w - len_w;
   assign dn_wrap  = dn_w + len_w;
   assign over_hi  = (up_w >= lim_w);
   assign under_lo = (cur_w < (base_w + mag_w));

   always_comb begin
      if (len == '0)
         circ_v = lin_v;
      else if (!dec)
         circ_v = over_hi ? up_wrap[AW-1:0] : up_w[AW-1:0];
      else
         circ_v = under_lo ? dn_wrap[AW-1:0] : dn_w[AW-1:0];
   end

   generate
      if (BREV_EN) begin : g_brev
         function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
            logic [AW-1:0] r;
            for (int k = 0; k < AW; k++) r[k] = v[AW-1-k];
            return r;
         endfunction

         logic [AW-1:0] rsum;
         assign rsum   = dec ? (flip(cur) - flip(mag)) : (flip(cur) + flip(mag));
         assign brev_v = flip(rsum);
      end else begin : g_nobrev
         assign brev_v = lin_v;
      end
   endgenerate

   always_comb begin
      unique case (amode_e'(mode))
         AM_CIRC: nxt = circ_v;
         AM_BREV: nxt = brev_v;
         default: nxt = lin_v;
      endcase
   end

endmodule

// File: rtl/circ_agu_bank.sv
module circ_agu_bank
   import circ_agu_pkg::*;
#(
   parameter int AW   = 16,
   parameter int NIDX = 4,
   parameter int SELW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_kind,
   input  logic [SELW-1:0] wr_sel,
   input  logic [AW-1:0]   wr_data,
   input  logic            up_en  [NPORT],
   input  logic [SELW-1:0] up_sel [NPORT],
   input  logic [AW-1:0]   up_val [NPORT],
   output logic [AW-1:0]   idx_q  [NIDX],
   output logic [AW-1:0]   base_q [NIDX],
   output logic [AW-1:0]   len_q  [NIDX],
   output logic [AW-1:0]   mod_q  [NIDX]
);

   generate
      for (genvar i = 0; i < NIDX; i++) begin : g_ptr
         logic wr_hit, hit0, hit1;
         assign wr_hit = wr_en && (wr_sel == SELW'(i));
         assign hit0   = up_en[0] && (up_sel[0] == SELW'(i));
         assign hit1   = up_en[1] && (up_sel[1] == SELW'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q[i]  <= '0;
               base_q[i] <= '0;
               len_q[i]  <= '0;
               mod_q[i]  <= '0;
            end else begin
               if (wr_hit && rkind_e'(wr_kind) == RK_BASE)   base_q[i] <= wr_data;
               if (wr_hit && rkind_e'(wr_kind) == RK_LENGTH) len_q[i]  <= wr_data;
               if (wr_hit && rkind_e'(wr_kind) == RK_MODIFY) mod_q[i]  <= wr_data;
               // priority: explicit write, then port 0, then port 1
               if (wr_hit && rkind_e'(wr_kind) == RK_INDEX) idx_q[i] <= wr_data;
               else if (hit0)                               idx_q[i] <= up_val[0];
               else if (hit1)                               idx_q[i] <= up_val[1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/circ_agu.sv
module circ_agu
   import circ_agu_pkg::*;
#(
   parameter  int AW      = 16,
   parameter  int NIDX    = 4,
   parameter  bit BREV_EN = 1'b1,
   localparam int SELW    = (NIDX > 1) ? $clog2(NIDX) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_kind,
   input  logic [SELW-1:0]    wr_sel,
   input  logic [AW-1:0]      wr_data,
   input  logic               p0_en,
   input  logic [SELW-1:0]    p0_sel,
   input  logic [1:0]         p0_mode,
   input  logic               p0_dec,
   input  logic               p0_use_imm,
   input  logic [AW-1:0]      p0_imm,
   input  logic               p1_en,
   input  logic [SELW-1:0]    p1_sel,
   input  logic [1:0]         p1_mode,
   input  logic               p1_dec,
   input  logic               p1_use_imm,
   input  logic [AW-1:0]      p1_imm,
   output logic [AW-1:0]      p0_addr,
   output logic [AW-1:0]      p1_addr,
   output logic [NIDX*AW-1:0] idx_flat
);

   if (AW < 4) begin : g_bad_aw
      $error("circ_agu: AW must be at least 4");
   end
   if (NIDX < 2 || (1 << SELW) != NIDX) begin : g_bad_nidx
      $error("circ_agu: NIDX must be a power of two, at least 2");
   end

   logic [AW-1:0]   idx_q  [NIDX];
   logic [AW-1:0]   base_q [NIDX];
   logic [AW-1:0]   len_q  [NIDX];
   logic [AW-1:0]   mod_q  [NIDX];

   logic            pen    [NPORT];
   logic [SELW-1:0] psel   [NPORT];
   logic [1:0]      pmode  [NPORT];
   logic            pdec   [NPORT];
   logic            puse   [NPORT];
   logic [AW-1:0]   pimm   [NPORT];

   logic [AW-1:0]   cur_v  [NPORT];
   logic [AW-1:0]   base_v [NPORT];
   logic [AW-1:0]   len_v  [NPORT];
   logic [AW-1:0]   mag_v  [NPORT];
   logic [AW-1:0]   nxt_v  [NPORT];

   assign pen[0] = p0_en;   assign psel[0] = p0_sel;   assign pmode[0] = p0_mode;
   assign pdec[0] = p0_dec; assign puse[0] = p0_use_imm; assign pimm[0] = p0_imm;
   assign pen[1] = p1_en;   assign psel[1] = p1_sel;   assign pmode[1] = p1_mode;
   assign pdec[1] = p1_dec; assign puse[1] = p1_use_imm; assign pimm[1] = p1_imm;

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         assign cur_v[p]  = idx_q[psel[p]];
         assign base_v[p] = base_q[psel[p]];
         assign len_v[p]  = len_q[psel[p]];
         assign mag_v[p]  = puse[p] ? pimm[p] : mod_q[psel[p]];

         circ_agu_step #(.AW(AW), .BREV_EN(BREV_EN)) u_step (
            .cur  (cur_v[p]),
            .base (base_v[p]),
            .len  (len_v[p]),
            .mag  (mag_v[p]),
            .mode (pmode[p]),
            .dec  (pdec[p]),
            .nxt  (nxt_v[p])
         );
      end

      for (genvar i = 0; i < NIDX; i++) begin : g_flat
         assign idx_flat[i*AW +: AW] = idx_q[i];
      end
   endgenerate

   circ_agu_bank #(.AW(AW), .NIDX(NIDX), .SELW(SELW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_kind (wr_kind),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .up_en   (pen),
      .up_sel  (psel),
      .up_val  (nxt_v),
      .idx_q   (idx_q),
      .base_q  (base_q),
      .len_q   (len_q),
      .mod_q   (mod_q)
   );

   assign p0_addr = cur_v[0];
   assign p1_addr = cur_v[1];

endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk #(
   parameter int AW   = 16,
   parameter int NIDX = 4,
   parameter int SELW = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_kind,
   input logic [SELW-1:0]    wr_sel,
   input logic [AW-1:0]      wr_data,
   input logic               p0_en,
   input logic [SELW-1:0]    p0_sel,
   input logic [1:0]         p0_mode,
   input logic               p1_en,
   input logic [SELW-1:0]    p1_sel,
   input logic [NIDX*AW-1:0] idx_flat,
   input logic [AW-1:0]      cur0,
   input logic [AW-1:0]      base0,
   input logic [AW-1:0]      len0,
   input logic [AW-1:0]      mag0,
   input logic [AW-1:0]      nxt0,
   input logic [AW-1:0]      nxt1
);

   function automatic logic [AW-1:0] pick(input logic [NIDX*AW-1:0] f,
                                          input logic [SELW-1:0] s);
      return f[s*AW +: AW];
   endfunction

   logic          idx_wr;
   logic [AW:0]   lo0, hi0, now0;
   logic          in_win0;

   assign idx_wr  = wr_en && (wr_kind == 2'd0);
   assign lo0     = {1'b0, base0};
   assign hi0     = lo0 + {1'b0, len0};
   assign now0    = {1'b0, cur0};
   assign in_win0 = (now0 >= lo0) && (now0 < hi0);

   // R1: a cycle in reset leaves every pointer at zero
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (idx_flat == '0));

   // R2 / R11: an index write lands regardless of updates to the same pointer
   assert_index_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (pick(idx_flat, $past(wr_sel)) == $past(wr_data)));

   // R3: no strobe, no change
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !p0_en && !p1_en) |=> $stable(idx_flat));

   // R4: a circular step from inside the window stays inside it
   assert_circ_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_en && p0_mode == 2'd1 && len0 != '0 && mag0 <= len0 && in_win0 &&
       !(idx_wr && wr_sel == p0_sel))
      |=> (({1'b0, pick(idx_flat, $past(p0_sel))} >= $past(lo0)) &&
           ({1'b0, pick(idx_flat, $past(p0_sel))} <  $past(hi0))));

   // R9: port 1 result is stored when it targets its own pointer
   assert_dual_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_en && p1_en && p0_sel != p1_sel && !(idx_wr && wr_sel == p1_sel))
      |=> (pick(idx_flat, $past(p1_sel)) == $past(nxt1)));

   // R10: port 0 wins a collision on one pointer
   assert_port0_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_en && p1_en && p0_sel == p1_sel && !(idx_wr && wr_sel == p0_sel))
      |=> (pick(idx_flat, $past(p0_sel)) == $past(nxt0)));

endmodule

bind circ_agu circ_agu_chk #(.AW(AW), .NIDX(NIDX), .SELW(SELW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_kind  (wr_kind),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .p0_en    (p0_en),
   .p0_sel   (p0_sel),
   .p0_mode  (p0_mode),
   .p1_en    (p1_en),
   .p1_sel   (p1_sel),
   .idx_flat (idx_flat),
   .cur0     (cur_v[0]),
   .base0    (base_v[0]),
   .len0     (len_v[0]),
   .mag0     (mag_v[0]),
   .nxt0     (nxt_v[0]),
   .nxt1     (nxt_v[1])
);

// File: tb/sim_circ_agu.sv
`timescale 1ns/1ps
module sim_circ_agu;

   localparam int AW   = 16;
   localparam int NIDX = 4;
   localparam int SELW = 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wr_en;
   logic [1:0]      wr_kind;
   logic [SELW-1:0] wr_sel;
   logic [AW-1:0]   wr_data;
   logic            p0_en, p0_dec, p0_use_imm;
   logic [SELW-1:0] p0_sel;
   logic [1:0]      p0_mode;
   logic [AW-1:0]   p0_imm;
   logic            p1_en, p1_dec, p1_use_imm;
   logic [SELW-1:0] p1_sel;
   logic [1:0]      p1_mode;
   logic [AW-1:0]   p1_imm;
   logic [AW-1:0]   p0_addr, p1_addr;
   logic [NIDX*AW-1:0] idx_flat;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   circ_agu #(.AW(AW), .NIDX(NIDX)) u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel), .wr_data(wr_data),
      .p0_en(p0_en), .p0_sel(p0_sel), .p0_mode(p0_mode), .p0_dec(p0_dec),
      .p0_use_imm(p0_use_imm), .p0_imm(p0_imm),
      .p1_en(p1_en), .p1_sel(p1_sel), .p1_mode(p1_mode), .p1_dec(p1_dec),
      .p1_use_imm(p1_use_imm), .p1_imm(p1_imm),
      .p0_addr(p0_addr), .p1_addr(p1_addr), .idx_flat(idx_flat)
   );

   function automatic logic [AW-1:0] ptr(input int i);
      return idx_flat[i*AW +: AW];
   endfunction

   task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic clear_strobes();
      wr_en = 1'b0; p0_en = 1'b0; p1_en = 1'b0;
   endtask

   // inputs are set just after a falling edge; this advances through one rising edge
   task automatic cycle();
      @(negedge clk);
      clear_strobes();
   endtask

   task automatic set_wr(input logic [1:0] k, input int s, input logic [AW-1:0] d);
      wr_en = 1'b1; wr_kind = k; wr_sel = SELW'(s); wr_data = d;
   endtask

   task automatic wreg(input logic [1:0] k, input int s, input logic [AW-1:0] d);
      set_wr(k, s, d);
      cycle();
   endtask

   task automatic set_p0(input int s, input logic [1:0] m, input logic dn,
                         input logic ui, input logic [AW-1:0] im);
      p0_en = 1'b1; p0_sel = SELW'(s); p0_mode = m; p0_dec = dn; p0_use_imm = ui; p0_imm = im;
   endtask

   task automatic set_p1(input int s, input logic [1:0] m, input logic dn,
                         input logic ui, input logic [AW-1:0] im);
      p1_en = 1'b1; p1_sel = SELW'(s); p1_mode = m; p1_dec = dn; p1_use_imm = ui; p1_imm = im;
   endtask

   task automatic t_reset();
      for (int i = 0; i < NIDX; i++) check("R1 reset pointer", ptr(i), '0);
   endtask

   task automatic t_write();
      wreg(2'd0, 0, 16'h0100);
      wreg(2'd0, 3, 16'hABCD);
      check("R2 index 0 write", ptr(0), 16'h0100);
      check("R2 index 3 write", ptr(3), 16'hABCD);
      check("R2 index 1 untouched", ptr(1), 16'h0000);
      // base write must not change the index
      wreg(2'd1, 3, 16'h1234);
      check("R2 base write leaves index", ptr(3), 16'hABCD);
   endtask

   task automatic t_linear();
      wreg(2'd0, 1, 16'h0010);
      wreg(2'd3, 1, 16'h0003);
      set_p0(1, 2'd0, 1'b0, 1'b0, 16'h0000);
      #0.5;
      check("R12 p0_addr shows pre-update value", p0_addr, 16'h0010);
      cycle();
      check("R7 R3 step from modify register", ptr(1), 16'h0013);
      set_p0(1, 2'd0, 1'b1, 1'b1, 16'h0005);
      cycle();
      check("R7 R3 immediate decrement", ptr(1), 16'h000E);
      wreg(2'd0, 1, 16'hFFFE);
      set_p1(1, 2'd3, 1'b0, 1'b1, 16'h0004);
      #0.5;
      check("R12 p1_addr shows pre-update value", p1_addr, 16'hFFFE);
      cycle();
      check("R3 mode 3 wraps modulo 2^AW", ptr(1), 16'h0002);
   endtask

   task automatic t_circ_inc();
      wreg(2'd1, 0, 16'h0100);
      wreg(2'd2, 0, 16'd10);
      wreg(2'd3, 0, 16'd4);
      wreg(2'd0, 0, 16'h0100);
      set_p0(0, 2'd1, 1'b0, 1'b0, 16'h0000); cycle();
      check("R4 circ inc 1", ptr(0), 16'h0104);
      set_p0(0, 2'd1, 1'b0, 1'b0, 16'h0000); cycle();
      check("R4 circ inc 2", ptr(0), 16'h0108);
      set_p0(0, 2'd1, 1'b0, 1'b0, 16'h0000); cycle();
      check("R4 circ inc wraps", ptr(0), 16'h0102);
      set_p0(0, 2'd1, 1'b0, 1'b0, 16'h0000); cycle();
      check("R4 circ inc 4", ptr(0), 16'h0106);
      set_p0(0, 2'd1, 1'b0, 1'b0, 16'h0000); cycle();
      check("R4 circ inc hits end exactly", ptr(0), 16'h0100);
   endtask

   task automatic t_circ_dec();
      wreg(2'd1, 2, 16'h0200);
      wreg(2'd2, 2, 16'd8);
      wreg(2'd0, 2, 16'h0202);
      set_p1(2, 2'd1, 1'b1, 1'b1, 16'd3); cycle();
      check("R5 circ dec wraps", ptr(2), 16'h0207);
      set_p1(2, 2'd1, 1'b1, 1'b1, 16'd3); cycle();
      check("R5 circ dec plain", ptr(2), 16'h0204);
      set_p1(2, 2'd1, 1'b1, 1'b1, 16'd4); cycle();
      check("R5 circ dec lands on base", ptr(2), 16'h0200);
   endtask

   task automatic t_len0();
      wreg(2'd1, 3, 16'h0050);
      wreg(2'd2, 3, 16'h0000);
      wreg(2'd0, 3, 16'h0040);
      set_p0(3, 2'd1, 1'b0, 1'b1, 16'h0020); cycle();
      check("R6 zero length is linear", ptr(3), 16'h0060);
   endtask

   task automatic t_brev();
      wreg(2'd0, 1, 16'h0000);
      set_p0(1, 2'd2, 1'b0, 1'b1, 16'h8000); cycle();
      check("R8 brev step 1", ptr(1), 16'h8000);
      set_p0(1, 2'd2, 1'b0, 1'b1, 16'h8000); cycle();
      check("R8 brev step 2", ptr(1), 16'h4000);
      set_p0(1, 2'd2, 1'b0, 1'b1, 16'h8000); cycle();
      check("R8 brev step 3", ptr(1), 16'hC000);
      set_p0(1, 2'd2, 1'b0, 1'b1, 16'h8000); cycle();
      check("R8 brev step 4", ptr(1), 16'h2000);
      set_p0(1, 2'd2, 1'b1, 1'b1, 16'h8000); cycle();
      check("R8 brev decrement", ptr(1), 16'hC000);
   endtask

   task automatic t_dual();
      wreg(2'd0, 0, 16'h0010);
      wreg(2'd0, 1, 16'h0020);
      set_p0(0, 2'd0, 1'b0, 1'b1, 16'd1);
      set_p1(1, 2'd0, 1'b1, 1'b1, 16'd2);
      cycle();
      check("R9 dual port 0", ptr(0), 16'h0011);
      check("R9 dual port 1", ptr(1), 16'h001E);
   endtask

   task automatic t_same();
      wreg(2'd0, 2, 16'h0030);
      set_p0(2, 2'd0, 1'b0, 1'b1, 16'd1);
      set_p1(2, 2'd0, 1'b0, 1'b1, 16'd5);
      cycle();
      check("R10 port 0 wins", ptr(2), 16'h0031);
   endtask

   task automatic t_wr_wins();
      wreg(2'd0, 0, 16'h0040);
      wreg(2'd0, 3, 16'h0500);
      set_wr(2'd0, 3, 16'h0777);
      set_p0(3, 2'd0, 1'b0, 1'b1, 16'd9);
      set_p1(0, 2'd0, 1'b0, 1'b1, 16'd1);
      cycle();
      check("R11 write beats update", ptr(3), 16'h0777);
      check("R11 other pointer still updated", ptr(0), 16'h0041);
   endtask

   task automatic t_reset_again();
      rst_n = 1'b0;
      @(negedge clk);
      for (int i = 0; i < NIDX; i++) check("R1 reset mid-run", ptr(i), '0);
      rst_n = 1'b1;
      @(negedge clk);
      wreg(2'd0, 1, 16'h0008);
      set_p0(1, 2'd0, 1'b0, 1'b0, 16'hFFFF); cycle();
      check("R1 modify register cleared by reset", ptr(1), 16'h0008);
   endtask

   initial begin
      rst_n = 1'b0;
      wr_kind = '0; wr_sel = '0; wr_data = '0;
      p0_sel = '0; p0_mode = '0; p0_dec = 1'b0; p0_use_imm = 1'b0; p0_imm = '0;
      p1_sel = '0; p1_mode = '0; p1_dec = 1'b0; p1_use_imm = 1'b0; p1_imm = '0;
      clear_strobes();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_linear();
      t_circ_inc();
      t_circ_dec();
      t_len0();
      t_brev();
      t_dual();
      t_same();
      t_wr_wins();
      t_reset_again();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired got %0d exp %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule